// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This engine sits on the host side of a byte-wide parallel flash device. The surrounding logic issues the program or erase command sequence and then hands the engine one request. The request holds the operation type, the polling method, the byte being written and the target address. From that point the engine repeatedly reads the target location and decides when the device's internal operation has finished.

Two completion tests are available. The first is bit-7 status: during a program, bit 7 reads as the inverse of the byte being written, and during an erase it reads 0. The second is bit-6 toggle detection: bit 6 flips on each read while the device is busy and stops flipping once it is done. When completion is seen, the other data bits may not be valid yet. The engine therefore waits a settle interval of about one microsecond, counted in clock cycles, and then reads the whole byte one last time.

Requests enter through a valid/ready handshake. `req_ready` is high only while the engine is idle, and a request is taken in any cycle where `req_valid` and `req_ready` are both high. The requester must hold the request fields stable in that cycle. There is no queue, so further requests wait until `req_ready` returns high. The outcome signals are plain single-cycle pulses with no back-pressure.

Top module: `flash_poll_engine`

## Requirements
- R1: After reset `req_ready` is 1, `rd_strobe` is 0 and `done`, `timed_out` and `addr_err` are 0. `req_ready` is high only while the engine is idle. A request presented while `req_ready` is low has no effect and produces no outcome pulse.
- R2: A request whose address is at or above `DEV_BYTES` issues no read. It raises `addr_err` for exactly one cycle, in the cycle after acceptance.
- R3: After a request is accepted, no read is issued while `poll_ok` is low. Polling begins once `poll_ok` is high.
- R4: When `req_toggle` is 0 and `req_erase` is 0 (program), a status read is complete when its bit 7 equals bit 7 of `req_data`.
- R5: When `req_toggle` is 0 and `req_erase` is 1 (erase), a status read is complete when its bit 7 is 1.
- R6: When `req_toggle` is 1, the first status read of a request only records bit 6. Each later status read is complete when its bit 6 equals bit 6 of the read before it.
- R7: After the completing status read is acknowledged, `rd_strobe` stays low for exactly `SETTLE_CYC` cycles (`CLK_MHZ*SETTLE_NS/1000`, at least 1). One final read follows. With an immediate acknowledge, the final read's acknowledge comes `SETTLE_CYC+1` cycles after the completing one.
- R8: `done` pulses for one cycle, in the cycle after the final read's acknowledge. `result` then holds that read's byte.
- R9: If `timeout_limit` status reads have all been incomplete, `timed_out` pulses for one cycle. No further read is issued and the engine returns to idle. A limit of 0 behaves as 1.
- R10: `rd_strobe` stays high and `rd_addr` stays equal to the request address until `rd_ack` is sampled high. Read data is taken in the acknowledge cycle.
- R11: At most one of `done`, `timed_out` and `addr_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_erase | input | 1 | 1 = erase operation, 0 = program |
| req_toggle | input | 1 | 1 = bit-6 toggle method, 0 = bit-7 status method |
| req_data | input | 8 | Byte being programmed |
| req_addr | input | ADDR_W | Byte address to poll |
| timeout_limit | input | TO_W | Maximum number of status reads |
| poll_ok | input | 1 | Issuing logic reports that polling may begin |
| rd_strobe | output | 1 | Read request to the device bus |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 8 | Read data |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | One-cycle timeout pulse |
| addr_err | output | 1 | One-cycle rejected-address pulse |
| result | output | 8 | Byte from the final read after settling |

## Verification
A behavioural device model answers the reads. For a set number of reads it stays busy, showing a complemented or zero bit 7 and a flipping bit 6. After that, its low bits stay wrong for the settle interval. Program requests are run with expected bit 7 both set and clear, which separates the program rule from the erase rule. Toggle requests are run with zero busy reads and with many busy reads, which shows that the first read is used only as a reference. A run with a slow acknowledge, a run held back by `poll_ok`, a run that times out and an out-of-range address show, in turn, the bus hold, the start gating, the read budget and the rejection. Each run checks the outcome pulse, the exact number of reads, the gap before the final read and the returned byte against values counted in the bench.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_READ,
    ST_SETTLE,
    ST_FINAL
  } poll_state_e;
endpackage

// File: rtl/fpoll_settle_timer.sv
module fpoll_settle_timer #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic             run;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= LOAD;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expire = run && (cnt == '0);

  // R7: the engine never restarts the settle wait while it is running
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !start);
  // R7: the wait always ends with an expire once started
  a_r7_runs_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run || expire));
endmodule

// File: rtl/fpoll_status_judge.sv
module fpoll_status_judge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sample,
  input  logic [7:0] data,
  input  logic       is_erase,
  input  logic       use_toggle,
  input  logic       exp_bit7,
  output logic       complete
);
  logic have_prev;
  logic prev_b6;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      have_prev <= 1'b0;
      prev_b6   <= 1'b0;
    end else if (sample) begin
      have_prev <= 1'b1;
      prev_b6   <= data[6];
    end
  end

  always_comb begin
    if (use_toggle)    complete = have_prev && (data[6] == prev_b6);
    else if (is_erase) complete = data[7];
    else               complete = (data[7] == exp_bit7);
  end

  // R6: a reference bit is recorded after any toggle-mode sample
  a_r6_ref_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !clear) |=> have_prev);
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DEV_BYTES = 524288,
  parameter int TO_W      = 16,
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_NS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_erase,
  input  logic              req_toggle,
  input  logic [7:0]        req_data,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TO_W-1:0]   timeout_limit,
  input  logic              poll_ok,
  output logic              rd_strobe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              timed_out,
  output logic              addr_err,
  output logic [7:0]        result
);
  localparam int SETTLE_RAW = (CLK_MHZ * SETTLE_NS) / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam logic [ADDR_W:0] DEV_END = (ADDR_W+1)'(DEV_BYTES);

  poll_state_e       state;
  logic [ADDR_W-1:0] addr_q;
  logic              exp7_q;
  logic              erase_q;
  logic              toggle_q;
  logic [TO_W-1:0]   limit_q;
  logic [TO_W-1:0]   tries;
  logic              complete;
  logic              settle_done;
  logic              status_ack;
  logic              last_try;
  logic              addr_bad;

  assign req_ready  = (state == ST_IDLE);
  assign rd_strobe  = (state == ST_READ) || (state == ST_FINAL);
  assign rd_addr    = addr_q;
  assign status_ack = (state == ST_READ) && rd_ack;
  assign addr_bad   = ({1'b0, req_addr} >= DEV_END);
  assign last_try   = ({1'b0, tries} + 1'b1) >= {1'b0, limit_q};

  fpoll_status_judge u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (state == ST_IDLE),
    .sample     (status_ack),
    .data       (rd_data),
    .is_erase   (erase_q),
    .use_toggle (toggle_q),
    .exp_bit7   (exp7_q),
    .complete   (complete)
  );

  fpoll_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (status_ack && complete),
    .expire (settle_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      exp7_q    <= 1'b0;
      erase_q   <= 1'b0;
      toggle_q  <= 1'b0;
      limit_q   <= '0;
      tries     <= '0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      addr_err  <= 1'b0;
      result    <= '0;
    end else begin
      done      <= 1'b0;
      timed_out <= 1'b0;
      addr_err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (addr_bad) begin
              addr_err <= 1'b1;
            end else begin
              addr_q   <= req_addr;
              exp7_q   <= req_data[7];
              erase_q  <= req_erase;
              toggle_q <= req_toggle;
              limit_q  <= (timeout_limit == '0) ? TO_W'(1) : timeout_limit;
              tries    <= '0;
              state    <= ST_ARM;
            end
          end
        end
        ST_ARM: begin
          if (poll_ok) state <= ST_READ;
        end
        ST_READ: begin
          if (rd_ack) begin
            if (complete) begin
              state <= ST_SETTLE;
            end else if (last_try) begin
              timed_out <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              tries <= tries + 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (settle_done) state <= ST_FINAL;
        end
        ST_FINAL: begin
          if (rd_ack) begin
            result <= rd_data;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: outcome pulses are mutually exclusive
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timed_out, addr_err}));
  // R3: no read while the issuing side withholds permission
  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARM && !poll_ok) |=> !rd_strobe);
  // R10: an unacknowledged read is held with a stable address
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_ack) |=> (rd_strobe && $stable(rd_addr)));
  // R2: an address error only follows an accepted request
  a_r2_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> $past(req_valid && req_ready));
  // R8: done only follows an acknowledged final read
  a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state == ST_FINAL && rd_ack));
  // R9: after a timeout pulse no read is active
  a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> !rd_strobe);
endmodule

// File: tb/flash_poll_engine_test.sv
module flash_poll_engine_test;
  localparam int S = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_erase = 1'b0;
  logic        req_toggle = 1'b0;
  logic [7:0]  req_data = 8'h00;
  logic [19:0] req_addr = '0;
  logic [15:0] timeout_limit = 16'd1000;
  logic        poll_ok = 1'b1;
  logic        rd_strobe;
  logic [19:0] rd_addr;
  logic        rd_ack;
  logic [7:0]  rd_data;
  logic        done, timed_out, addr_err;
  logic [7:0]  result;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // device model state
  int         busy_left = 0;
  int         settle_left = 0;
  int         ack_delay = 0;
  int         wcnt = 0;
  int         reads = 0;
  int         last_ack = 0;
  int         prev_ack = 0;
  logic       tog = 1'b0;
  logic       dev_erase = 1'b0;
  logic [7:0] true_byte = 8'h00;
  logic [19:0] target = '0;
  logic       quiet = 1'b0;

  always #5 clk = ~clk;

  flash_poll_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_toggle(req_toggle), .req_data(req_data),
    .req_addr(req_addr), .timeout_limit(timeout_limit), .poll_ok(poll_ok),
    .rd_strobe(rd_strobe), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .done(done), .timed_out(timed_out), .addr_err(addr_err), .result(result)
  );

  assign rd_ack = rd_strobe && (wcnt == ack_delay);

  always_comb begin
    if (busy_left > 0)
      rd_data = {(dev_erase ? 1'b0 : ~true_byte[7]), tog, ~true_byte[5:0]};
    else if (settle_left > 0)
      rd_data = {true_byte[7], tog, ~true_byte[5:0]};
    else
      rd_data = true_byte;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (settle_left > 0) settle_left <= settle_left - 1;
    if (rd_strobe) begin
      if (rd_ack) begin
        wcnt     <= 0;
        reads    <= reads + 1;
        prev_ack <= last_ack;
        last_ack <= cyc;
        if (busy_left > 0) begin
          busy_left <= busy_left - 1;
          tog       <= ~tog;
          if (busy_left == 1) settle_left <= S;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // per-cycle reference comparisons
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_strobe && rd_addr !== target) begin
        failures++;
        $display("FAIL R10 rd_addr=%h expected=%h", rd_addr, target);
      end
      if ((32'(done) + 32'(timed_out) + 32'(addr_err)) > 1) begin
        failures++;
        $display("FAIL R11 pulses=%b%b%b expected at most one", done, timed_out, addr_err);
      end
      if (quiet && rd_strobe) begin
        failures++;
        $display("FAIL R3/R9 rd_strobe=1 expected=0 in quiet window");
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic setup_dev(input logic er, input logic [7:0] tb, input int busy,
                           input logic [19:0] a, input int dly);
    @(negedge clk);
    dev_erase = er;
    true_byte = tb;
    busy_left = busy;
    settle_left = (busy == 0) ? S : 0;
    ack_delay = dly;
    reads = 0;
    target = a;
  endtask

  task automatic send(input logic er, input logic tg, input logic [7:0] d,
                      input logic [19:0] a, input logic [15:0] lim);
    req_erase = er; req_toggle = tg; req_data = d; req_addr = a;
    timeout_limit = lim; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // 1 done, 2 timeout, 3 addr_err, 0 none
  task automatic wait_outcome(output int kind);
    kind = 0;
    for (int i = 0; i < 3000 && kind == 0; i++) begin
      if (done) kind = 1;
      else if (timed_out) kind = 2;
      else if (addr_err) kind = 3;
      else @(negedge clk);
    end
    @(negedge clk);
    check("R8 pulse width", int'(done || timed_out || addr_err), 0);
  endtask

  int k;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", int'(req_ready), 1);
    check("R1 reset strobe", int'(rd_strobe), 0);
    check("R1 reset pulses", int'(done || timed_out || addr_err), 0);

    // R4 program, expected bit7 set
    setup_dev(1'b0, 8'hA5, 5, 20'h01234, 0);
    send(1'b0, 1'b0, 8'hA5, 20'h01234, 16'd100);
    wait_outcome(k);
    check("R4 outcome", k, 1);
    check("R8 result", int'(result), 8'hA5);
    check("R4 reads", reads, 7);
    check("R7 settle gap", last_ack - prev_ack, S + 1);

    // R4 program, expected bit7 clear (busy shows 1)
    setup_dev(1'b0, 8'h35, 3, 20'h7FFFF, 0);
    send(1'b0, 1'b0, 8'h35, 20'h7FFFF, 16'd100);
    wait_outcome(k);
    check("R4 outcome bit7=0", k, 1);
    check("R4 reads bit7=0", reads, 5);
    check("R8 result bit7=0", int'(result), 8'h35);

    // R5 erase
    setup_dev(1'b1, 8'hFF, 4, 20'h00010, 0);
    send(1'b1, 1'b0, 8'h00, 20'h00010, 16'd100);
    wait_outcome(k);
    check("R5 outcome", k, 1);
    check("R5 reads", reads, 6);
    check("R5 result", int'(result), 8'hFF);

    // R6 toggle program, many busy reads
    setup_dev(1'b0, 8'h5C, 6, 20'h00400, 0);
    send(1'b0, 1'b1, 8'h5C, 20'h00400, 16'd100);
    wait_outcome(k);
    check("R6 outcome", k, 1);
    check("R6 reads", reads, 9);
    check("R6 result", int'(result), 8'h5C);

    // R6 toggle erase, already complete: first read is only a reference
    setup_dev(1'b1, 8'hFF, 0, 20'h00020, 0);
    send(1'b1, 1'b1, 8'h00, 20'h00020, 16'd100);
    wait_outcome(k);
    check("R6 outcome idle device", k, 1);
    check("R6 reads idle device", reads, 3);

    // R9 timeout
    setup_dev(1'b0, 8'h81, 50, 20'h00030, 0);
    send(1'b0, 1'b0, 8'h81, 20'h00030, 16'd10);
    wait_outcome(k);
    check("R9 outcome", k, 2);
    check("R9 reads", reads, 10);
    quiet = 1'b1;
    repeat (20) @(negedge clk);
    quiet = 1'b0;
    check("R9 no further reads", reads, 10);
    check("R9 back to idle", int'(req_ready), 1);

    // R2 out-of-range address
    setup_dev(1'b0, 8'h11, 2, 20'h80000, 0);
    send(1'b0, 1'b0, 8'h11, 20'h80000, 16'd100);
    check("R2 addr_err pulse", int'(addr_err), 1);
    wait_outcome(k);
    check("R2 reads", reads, 0);

    // R3 gating, and R1 requests ignored while busy
    setup_dev(1'b0, 8'hC3, 2, 20'h00050, 0);
    poll_ok = 1'b0;
    send(1'b0, 1'b0, 8'hC3, 20'h00050, 16'd100);
    check("R1 ready low when busy", int'(req_ready), 0);
    quiet = 1'b1;
    req_addr = 20'hFFFFF; req_valid = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (addr_err) check("R1 ignored request", 1, 0);
    end
    req_valid = 1'b0;
    req_addr = 20'h00050;
    check("R3 no reads gated", reads, 0);
    quiet = 1'b0;
    poll_ok = 1'b1;
    wait_outcome(k);
    check("R3 outcome after gate", k, 1);
    check("R3 result", int'(result), 8'hC3);

    // R10 slow acknowledge
    setup_dev(1'b0, 8'h96, 2, 20'h00060, 3);
    send(1'b0, 1'b0, 8'h96, 20'h00060, 16'd100);
    wait_outcome(k);
    check("R10 outcome", k, 1);
    check("R10 result", int'(result), 8'h96);
    check("R10 reads", reads, 4);
    check("R7 gap slow ack", last_ack - prev_ack, S + 1 + 3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule